// File: doc/BRIEF.md
# Carry-Save Multiply-Accumulate Datapath

This block evaluates a fixed sum of products in one pass: Y = ±(A0×B0) ± (A1×B1) ± C + (the number of set bits on a small addend vector). The result wraps modulo 2^W. Each of the three operand ports has its own compile-time choice of two's-complement or unsigned interpretation and its own choice of adding or subtracting. The block suits places where several products feed one accumulator value and a single wide carry chain is wanted instead of one chain per term.

Inside, every operand is widened to W bits. Each product is expanded into one partial-product row per multiplier bit, with signed correction on the multiplier's top bit. Subtraction is folded in by inverting rows. All the "+1" terms that subtraction needs are merged into one constant row. Layers of 3:2 full-adder banks then reduce the rows. Loose single-bit addends ride in the empty low bit of each carry row, and one carry-propagate adder produces the final sum. An output register, chosen by a parameter, adds one cycle of latency and does not change the value.

Top module: `mac_csa_acc`

## Requirements
- R1: With OUT_REG = 1, the output y is all zeros while rst_n is low, whatever the operand inputs are.
- R2: With OUT_REG = 1, y shows the result for the operands present at the previous rising clock edge. With OUT_REG = 0, y follows the current operands with no clock involved.
- R3: An unsigned product port zero-extends both of its operands. For example, all-ones 6-bit and 5-bit operands give 63×31.
- R4: A signed product port sign-extends both of its operands. The most negative values give their true signed product modulo 2^W, for example (−128)×(−128) = 16384.
- R5: A product port flagged for subtraction contributes the two's-complement negation of its product.
- R6: The C port is sign- or zero-extended according to its flag and is added or subtracted according to its flag. The 12-bit pattern 0x800 counts as −2048 when signed.
- R7: Each bit set in the addend vector `bits` adds exactly 1 to the result, independent of its position in the vector.
- R8: For any operand values, y equals ±A0·B0 ± A1·B1 ± C + popcount(bits), taken modulo 2^W.
- R9: All-zero operands and addends give y = 0, for every flag setting.
- R10: Operands held constant give a y that does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a0 | input | A0_W | First operand of product 0 |
| b0 | input | B0_W | Second operand of product 0 |
| a1 | input | A1_W | First operand of product 1 |
| b1 | input | B1_W | Second operand of product 1 |
| c | input | C_W | Plain addend |
| bits | input | NBITS | Single-bit addends, each worth 1 |
| y | output | W | Result modulo 2^W |

## Verification
A fault in a partial-product row, such as a wrong signed correction or a missing inversion, changes y only for operands that exercise that row's multiplier bit. Extreme values such as the most negative signed input and all-ones unsigned input are therefore driven on purpose. A misplaced carry bit or a lost slot addend produces an error of a power of two, and it appears in the very next result (one cycle later when registered). Random vectors compared against a direct arithmetic model catch the remaining faults in the compressor wiring. A second instance with inverted flag choices and no output register covers the other sign and subtract settings.

// File: rtl/mac_csa_pkg.sv
package mac_csa_pkg;

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // rows produced by one product port: one per multiplier bit, plus a
  // correction row when signed
  function automatic int prod_rows(int wx, int wy, int w, bit sgn);
    return imin(imin(wx, wy), w) + (sgn ? 1 : 0);
  endfunction

  // row count after one layer of 3:2 compression
  function automatic int next_rows(int n);
    return (n > 2) ? 2 * (n / 3) + (n % 3) : n;
  endfunction

  function automatic int rows_at(int n0, int l);
    int n;
    n = n0;
    for (int i = 0; i < l; i++) n = next_rows(n);
    return n;
  endfunction

  function automatic int tree_layers(int n0);
    int n;
    int l;
    n = n0;
    l = 0;
    while (n > 2) begin
      n = next_rows(n);
      l++;
    end
    return l;
  endfunction

  // compressors placed in all layers before layer l
  function automatic int comps_before(int n0, int l);
    int n;
    int c;
    n = n0;
    c = 0;
    for (int i = 0; i < l; i++) begin
      c += n / 3;
      n = next_rows(n);
    end
    return c;
  endfunction

  // smallest number of extra rows so that carry slots plus extra rows
  // can hold every single-bit addend
  function automatic int extra_rows(int r0, int nb);
    for (int e = 0; e <= nb; e++)
      if (imax(r0 + e - 2, 0) + e >= nb) return e;
    return nb;
  endfunction

endpackage

// File: rtl/mac_fa_row.sv
module mac_fa_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  input  logic         fill_bit,
  output logic [W-1:0] sum_row,
  output logic [W-1:0] cy_row
);
  logic [W-1:0] half;
  logic [W-1:0] cout;

  assign half    = in_a ^ in_b;
  assign sum_row = half ^ in_c;
  assign cout    = (in_a & in_b) | (in_c & half);
  // carries move up one weight; the freed bit 0 takes a pending addend
  assign cy_row  = {cout[W-2:0], fill_bit};
endmodule

// File: rtl/mac_prod_rows.sv
module mac_prod_rows
  import mac_csa_pkg::*;
#(
  parameter int W   = 16,
  parameter int WX  = 8,
  parameter int WY  = 8,
  parameter bit SGN = 1'b0,
  parameter bit SUB = 1'b0,
  localparam int NR = prod_rows(WX, WY, W, SGN)
) (
  input  logic [WX-1:0] x,
  input  logic [WY-1:0] y,
  output logic [W-1:0]  rows [NR]
);
  localparam int WM = (WX >= WY) ? WX : WY;   // multiplicand width
  localparam int WN = (WX >= WY) ? WY : WX;   // multiplier width
  localparam int NB = imin(WN, W);

  logic [WM-1:0] m_raw;
  logic [WN-1:0] n_raw;
  logic [W-1:0]  m_ext;

  if (WX >= WY) begin : g_x_wide
    assign m_raw = x;
    assign n_raw = y;
  end else begin : g_y_wide
    assign m_raw = y;
    assign n_raw = x;
  end

  for (genvar b = 0; b < W; b++) begin : g_ext
    if (b < WM) begin : g_in
      assign m_ext[b] = m_raw[b];
    end else if (SGN) begin : g_sx
      assign m_ext[b] = m_raw[WM-1];
    end else begin : g_zx
      assign m_ext[b] = 1'b0;
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_row
    logic [W-1:0] sh;
    logic [W-1:0] raw;
    assign sh = m_ext << i;
    if (SGN && (i == NB - 1)) begin : g_sign
      // negative weight: inverted upper part, low i bits cleared
      assign raw = (~sh & ({W{1'b1}} << i)) & {W{n_raw[i]}};
    end else begin : g_plain
      assign raw = sh & {W{n_raw[i]}};
    end
    assign rows[i] = SUB ? ~raw : raw;
  end

  if (SGN) begin : g_corr
    logic [W-1:0] corr;
    assign corr     = {{(W-1){1'b0}}, n_raw[NB-1]} << (NB - 1);
    assign rows[NB] = SUB ? ~corr : corr;
  end
endmodule

// File: rtl/mac_csa_tree.sv
module mac_csa_tree
  import mac_csa_pkg::*;
#(
  parameter int W     = 16,
  parameter int NR0   = 4,
  parameter int NBITS = 1,
  localparam int NEX   = extra_rows(NR0, NBITS),
  localparam int NIN   = NR0 + NEX,
  localparam int NL    = tree_layers(NIN),
  localparam int NSLOT = imin(NBITS, imax(NIN - 2, 0))
) (
  input  logic [W-1:0]     rows [NR0],
  input  logic [NBITS-1:0] bits,
  output logic [W-1:0]     sum
);
  logic [W-1:0] lay [NL+1][NIN];

  for (genvar r = 0; r < NR0; r++) begin : g_in
    assign lay[0][r] = rows[r];
  end

  // addends that found no carry slot get a row of their own
  for (genvar e = 0; e < NEX; e++) begin : g_ex
    if (NSLOT + e < NBITS) begin : g_b
      assign lay[0][NR0+e] = {{(W-1){1'b0}}, bits[NSLOT+e]};
    end else begin : g_z
      assign lay[0][NR0+e] = '0;
    end
  end

  for (genvar l = 0; l < NL; l++) begin : g_lay
    localparam int N  = rows_at(NIN, l);
    localparam int G  = N / 3;
    localparam int NN = rows_at(NIN, l + 1);
    localparam int CB = comps_before(NIN, l);

    for (genvar g = 0; g < G; g++) begin : g_grp
      logic fill;
      if (CB + g < NSLOT) begin : g_fill
        assign fill = bits[CB+g];
      end else begin : g_nofill
        assign fill = 1'b0;
      end
      mac_fa_row #(.W(W)) u_fa (
        .in_a    (lay[l][3*g]),
        .in_b    (lay[l][3*g+1]),
        .in_c    (lay[l][3*g+2]),
        .fill_bit(fill),
        .sum_row (lay[l+1][2*g]),
        .cy_row  (lay[l+1][2*g+1])
      );
    end

    for (genvar j = 0; j < N % 3; j++) begin : g_pass
      assign lay[l+1][2*G+j] = lay[l][3*G+j];
    end

    for (genvar r = NN; r < NIN; r++) begin : g_idle
      assign lay[l+1][r] = '0;
    end
  end

  if (rows_at(NIN, NL) >= 2) begin : g_cpa
    assign sum = lay[NL][0] + lay[NL][1];
  end else begin : g_one
    assign sum = lay[NL][0];
  end
endmodule

// File: rtl/mac_csa_acc.sv
module mac_csa_acc
  import mac_csa_pkg::*;
#(
  parameter int W         = 16,
  parameter int A0_W      = 8,
  parameter int B0_W      = 8,
  parameter int A1_W      = 6,
  parameter int B1_W      = 5,
  parameter int C_W       = 12,
  parameter int NBITS     = 3,
  parameter bit P0_SIGNED = 1'b1,
  parameter bit P0_SUB    = 1'b0,
  parameter bit P1_SIGNED = 1'b0,
  parameter bit P1_SUB    = 1'b1,
  parameter bit C_SIGNED  = 1'b1,
  parameter bit C_SUB     = 1'b1,
  parameter bit OUT_REG   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [A0_W-1:0]  a0,
  input  logic [B0_W-1:0]  b0,
  input  logic [A1_W-1:0]  a1,
  input  logic [B1_W-1:0]  b1,
  input  logic [C_W-1:0]   c,
  input  logic [NBITS-1:0] bits,
  output logic [W-1:0]     y
);
  localparam int NRP0 = prod_rows(A0_W, B0_W, W, P0_SIGNED);
  localparam int NRP1 = prod_rows(A1_W, B1_W, W, P1_SIGNED);
  localparam int NR0  = NRP0 + NRP1 + 2;
  // every inverted row owes +1; all of them collapse into one constant
  localparam int KSUM = (P0_SUB ? NRP0 : 0) + (P1_SUB ? NRP1 : 0) + (C_SUB ? 1 : 0);
  localparam logic [W-1:0] KROW = W'(KSUM);

  logic [W-1:0] p0_rows  [NRP0];
  logic [W-1:0] p1_rows  [NRP1];
  logic [W-1:0] all_rows [NR0];
  logic [W-1:0] c_ext;
  logic [W-1:0] sum;

  mac_prod_rows #(.W(W), .WX(A0_W), .WY(B0_W), .SGN(P0_SIGNED), .SUB(P0_SUB)) u_p0 (
    .x(a0), .y(b0), .rows(p0_rows)
  );

  mac_prod_rows #(.W(W), .WX(A1_W), .WY(B1_W), .SGN(P1_SIGNED), .SUB(P1_SUB)) u_p1 (
    .x(a1), .y(b1), .rows(p1_rows)
  );

  for (genvar b = 0; b < W; b++) begin : g_cext
    if (b < C_W) begin : g_in
      assign c_ext[b] = c[b];
    end else if (C_SIGNED) begin : g_sx
      assign c_ext[b] = c[C_W-1];
    end else begin : g_zx
      assign c_ext[b] = 1'b0;
    end
  end

  for (genvar i = 0; i < NRP0; i++) begin : g_r0
    assign all_rows[i] = p0_rows[i];
  end
  for (genvar i = 0; i < NRP1; i++) begin : g_r1
    assign all_rows[NRP0+i] = p1_rows[i];
  end
  assign all_rows[NRP0+NRP1]   = C_SUB ? ~c_ext : c_ext;
  assign all_rows[NRP0+NRP1+1] = KROW;

  mac_csa_tree #(.W(W), .NR0(NR0), .NBITS(NBITS)) u_tree (
    .rows(all_rows), .bits(bits), .sum(sum)
  );

  if (OUT_REG) begin : g_reg
    logic [W-1:0] y_d;
    logic [W-1:0] y_q;

    always_comb begin
      y_d = sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) y_q <= '0;
      else        y_q <= y_d;
    end

    assign y = y_q;
  end else begin : g_comb
    assign y = sum;
  end
endmodule

// File: rtl/mac_csa_acc_chk.sv
module mac_csa_acc_chk #(
  parameter int W         = 16,
  parameter int A0_W      = 8,
  parameter int B0_W      = 8,
  parameter int A1_W      = 6,
  parameter int B1_W      = 5,
  parameter int C_W       = 12,
  parameter int NBITS     = 3,
  parameter bit P0_SIGNED = 1'b1,
  parameter bit P0_SUB    = 1'b0,
  parameter bit P1_SIGNED = 1'b0,
  parameter bit P1_SUB    = 1'b1,
  parameter bit C_SIGNED  = 1'b1,
  parameter bit C_SUB     = 1'b1,
  parameter bit OUT_REG   = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [A0_W-1:0]  a0,
  input logic [B0_W-1:0]  b0,
  input logic [A1_W-1:0]  a1,
  input logic [B1_W-1:0]  b1,
  input logic [C_W-1:0]   c,
  input logic [NBITS-1:0] bits,
  input logic [W-1:0]     y
);
  function automatic logic [W-1:0] widen(logic [63:0] v, int w, bit s);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (i < w) ? v[i] : (s & v[w-1]);
    return r;
  endfunction

  logic [W-1:0] t0, t1, tc, ref_val;
  logic         ops_zero;
  logic         primed;
  logic [A0_W+B0_W+A1_W+B1_W+C_W+NBITS-1:0] inp;

  assign t0 = widen(64'(a0), A0_W, P0_SIGNED) * widen(64'(b0), B0_W, P0_SIGNED);
  assign t1 = widen(64'(a1), A1_W, P1_SIGNED) * widen(64'(b1), B1_W, P1_SIGNED);
  assign tc = widen(64'(c), C_W, C_SIGNED);
  assign ref_val = (P0_SUB ? -t0 : t0) + (P1_SUB ? -t1 : t1) + (C_SUB ? -tc : tc)
                 + W'($countones(bits));
  assign ops_zero = (a0 == '0) && (b0 == '0) && (a1 == '0) && (b1 == '0) && (c == '0);
  assign inp = {a0, b0, a1, b1, c, bits};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  if (OUT_REG) begin : g_reg
    always @(negedge clk) begin
      if (!rst_n) begin
        p_reset_zero_r1: assert (y == '0) else $error("y not zero in reset");
      end
    end

    p_latency_model_r2: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> y == $past(ref_val));

    p_zero_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(ops_zero && bits == '0)) |-> y == '0);

    p_bits_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(ops_zero)) |-> y == W'($countones($past(bits))));

    p_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $stable(inp)) |=> $stable(y));
  end else begin : g_comb
    p_model_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
      y == ref_val);

    p_zero_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ops_zero && bits == '0) |-> y == '0);

    p_bits_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ops_zero |-> y == W'($countones(bits)));

    p_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $stable(inp)) |-> $stable(y));
  end
endmodule

bind mac_csa_acc mac_csa_acc_chk #(
  .W(W), .A0_W(A0_W), .B0_W(B0_W), .A1_W(A1_W), .B1_W(B1_W), .C_W(C_W),
  .NBITS(NBITS), .P0_SIGNED(P0_SIGNED), .P0_SUB(P0_SUB), .P1_SIGNED(P1_SIGNED),
  .P1_SUB(P1_SUB), .C_SIGNED(C_SIGNED), .C_SUB(C_SUB), .OUT_REG(OUT_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .a0(a0), .b0(b0), .a1(a1), .b1(b1),
  .c(c), .bits(bits), .y(y)
);

// File: tb/mac_csa_acc_tb_top.sv
module mac_csa_acc_tb_top;
  localparam int W = 16;

  logic        clk;
  logic        rst_n;
  logic [7:0]  a0, b0;
  logic [5:0]  a1;
  logic [4:0]  b1;
  logic [11:0] c;
  logic [2:0]  bits;
  logic [W-1:0] y_main, y_alt;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct {
    logic [W-1:0] e_main;
    logic [W-1:0] e_alt;
    string        tag;
  } item_t;
  item_t sb [$];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // registered instance: P0 signed add, P1 unsigned sub, C signed sub
  mac_csa_acc dut_i (
    .clk(clk), .rst_n(rst_n), .a0(a0), .b0(b0), .a1(a1), .b1(b1),
    .c(c), .bits(bits), .y(y_main)
  );

  // combinational instance with every flag flipped
  mac_csa_acc #(
    .P0_SIGNED(1'b0), .P0_SUB(1'b1), .P1_SIGNED(1'b1), .P1_SUB(1'b0),
    .C_SIGNED(1'b0), .C_SUB(1'b0), .OUT_REG(1'b0)
  ) dut_alt_i (
    .clk(clk), .rst_n(rst_n), .a0(a0), .b0(b0), .a1(a1), .b1(b1),
    .c(c), .bits(bits), .y(y_alt)
  );

  function automatic logic [W-1:0] ext(logic [63:0] v, int w, bit s);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (i < w) ? v[i] : (s & v[w-1]);
    return r;
  endfunction

  function automatic logic [W-1:0] model(bit s0, bit u0, bit s1, bit u1, bit sc, bit uc);
    logic [W-1:0] p0, p1, cc, r;
    p0 = ext(64'(a0), 8, s0) * ext(64'(b0), 8, s0);
    p1 = ext(64'(a1), 6, s1) * ext(64'(b1), 5, s1);
    cc = ext(64'(c), 12, sc);
    r  = (u0 ? -p0 : p0) + (u1 ? -p1 : p1) + (uc ? -cc : cc);
    r  = r + W'(bits[0]) + W'(bits[1]) + W'(bits[2]);
    return r;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [7:0] va0, logic [7:0] vb0, logic [5:0] va1,
                       logic [4:0] vb1, logic [11:0] vc, logic [2:0] vbits, string tag);
    item_t it;
    @(negedge clk);
    a0 = va0; b0 = vb0; a1 = va1; b1 = vb1; c = vc; bits = vbits;
    it.e_main = model(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    it.e_alt  = model(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    it.tag    = tag;
    sb.push_back(it);
  endtask

  // monitor: registered result appears after the posedge following the drive
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check({it.tag, " registered"}, y_main, it.e_main);
        check({it.tag, " combinational R2"}, y_alt, it.e_alt);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a0 = 8'h5a; b0 = 8'hc3; a1 = 6'h2f; b1 = 5'h11; c = 12'h7f0; bits = 3'b101;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset holds y", y_main, '0);
    check("R2 comb during reset", y_alt, model(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
    @(negedge clk);
    rst_n = 1'b1;

    drive(8'h00, 8'h00, 6'h00, 5'h00, 12'h000, 3'b000, "R9 zero");
    drive(8'h00, 8'h00, 6'h3f, 5'h1f, 12'h000, 3'b000, "R3 all-ones unsigned");
    drive(8'hff, 8'hff, 6'h00, 5'h00, 12'h000, 3'b000, "R3 R4 all-ones 8b");
    drive(8'h80, 8'h80, 6'h00, 5'h00, 12'h000, 3'b000, "R4 min x min");
    drive(8'h80, 8'h7f, 6'h00, 5'h00, 12'h000, 3'b000, "R4 min x max");
    drive(8'h7f, 8'h80, 6'h00, 5'h00, 12'h000, 3'b000, "R4 max x min");
    drive(8'hff, 8'h80, 6'h00, 5'h00, 12'h000, 3'b000, "R4 -1 x min");
    drive(8'h00, 8'h00, 6'h05, 5'h03, 12'h000, 3'b000, "R5 subtract product");
    drive(8'h00, 8'h00, 6'h20, 5'h10, 12'h000, 3'b000, "R5 R4 signed min alt");
    drive(8'h00, 8'h00, 6'h00, 5'h00, 12'h800, 3'b000, "R6 C most negative");
    drive(8'h00, 8'h00, 6'h00, 5'h00, 12'hfff, 3'b000, "R6 C all ones");
    drive(8'h00, 8'h00, 6'h00, 5'h00, 12'h001, 3'b000, "R6 C one");
    drive(8'h00, 8'h00, 6'h00, 5'h00, 12'h000, 3'b001, "R7 one bit");
    drive(8'h00, 8'h00, 6'h00, 5'h00, 12'h000, 3'b100, "R7 top bit");
    drive(8'h00, 8'h00, 6'h00, 5'h00, 12'h000, 3'b011, "R7 two bits");
    drive(8'h00, 8'h00, 6'h00, 5'h00, 12'h000, 3'b111, "R7 all bits");
    drive(8'hff, 8'hff, 6'h3f, 5'h1f, 12'hfff, 3'b111, "R8 all ones");
    drive(8'h80, 8'h80, 6'h20, 5'h10, 12'h800, 3'b111, "R8 all minimum");
    for (int k = 0; k < 3; k++)
      drive(8'h93, 8'h6e, 6'h1b, 5'h0d, 12'ha5c, 3'b010, "R10 held operands");
    for (int k = 0; k < 400; k++)
      drive(8'($urandom), 8'($urandom), 6'($urandom), 5'($urandom),
            12'($urandom), 3'($urandom), "R8 random");

    while (sb.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule